// File: doc/BRIEF.md
# 8-bit CPU Arithmetic-Logic Unit with Status Word

This block is the arithmetic core of a small 8-bit processor. Each cycle it takes an operation code, the accumulator byte, a second operand byte, the 16-bit register pair (Y in the upper byte, A in the lower byte) and a 16-bit memory word. From these it forms a 16-bit result without any clock delay. It also holds the processor status byte in a register. That register is written only on a clock edge where `opValid` is high and the code is a defined one.

Byte results come out zero-extended in `result[7:0]`. Register-pair results and the product use all 16 bits. Divide puts the quotient in the low byte and the remainder in the high byte. Compare operations and flag-only operations drive `result` to zero, so the surrounding core writes nothing back. The carry input of add and subtract with carry is the C bit of the status register. Instruction fetch, operand addressing and memory access belong to the surrounding core.

The status byte is laid out, from bit 7 down to bit 0, as N (negative), V (overflow), P (page select), B (break), H (half-carry), I (interrupt enable), Z (zero) and C (carry).

Top module: `cpu8_alu`

## Requirements
- R1: After reset the status byte reads 0x00. The status byte changes only on a rising clock edge where `opValid` is 1 and `opCode` is below 28. While `opValid` is 0 it holds its value.
- R2: ADC (code 0) produces A + operand + C in `result[7:0]`. C is set when the sum exceeds 0xFF. H is bit 4 of (A ^ operand ^ sum). V is bit 7 of (A ^ sum) & (operand ^ sum). Z and N come from the 8-bit sum. P, B and I are kept.
- R3: SBC (code 1) produces A - operand - (1 - C), so a clear carry acts as a borrow. C is set when no borrow occurs. V is bit 7 of (A ^ diff) & (A ^ operand). H is bit 4 of (A ^ operand ^ diff). Z and N come from the difference.
- R4: CMP (code 2) subtracts the operand from A with no borrow in. It writes only C, Z and N, using the same rules as SBC. V, H, P, B and I are kept, and `result` is 0.
- R5: AND (3), OR (4), XOR (5), INC (11), DEC (12) and MOV (13) write only Z and N, with N taken from bit 7 of the result. INC and DEC act on A and wrap around. MOV passes the operand through.
- R6: ASL (6) and ROL (8) shift A left, and bit 7 goes to C. LSR (7) and ROR (9) shift A right, and bit 0 goes to C. The fill bit is 0 for the plain shifts and the old C for the rotates. Z and N come from the shifted byte.
- R7: XCN (10) swaps the two nibbles of A and sets Z and N from the swapped byte.
- R8: ADDW (14) computes pair + word with no carry in. SUBW (15) computes pair - word with no borrow in. C is bit 16 of the sum, or no-borrow for SUBW. V uses bit 15 with the 8-bit formulas. Z tests all 16 bits and N is bit 15. H is kept.
- R9: CMPW (16) subtracts the word from the pair. It writes only C, Z and N, keeps V and H, and drives `result` to 0.
- R10: MUL (17) outputs the 16-bit product of the pair's low byte and high byte. N is product bit 15 and Z tests the full product. V, H and C are kept.
- R11: DIV (18) divides the 16-bit pair by the operand byte. The quotient goes to `result[7:0]` and the remainder to `result[15:8]`. V is cleared, and Z and N come from the quotient.
- R12: A divide whose divisor is 0, or whose pair high byte is greater than or equal to the divisor, gives quotient 0xFF and remainder equal to the pair's low byte, and sets V. It completes in the same cycle as any other divide.
- R13: The flag operations act on single bits and leave the other bits unchanged: CLRC (19) clears C (bit 0), SETC (20) sets C, NOTC (21) inverts C, CLRV (22) clears V (bit 6), CLRP (23) clears P (bit 5), SETP (24) sets P, EI (25) sets I (bit 2) and DI (26) clears I. Each drives `result` to 0.
- R14: LDPS (27) loads all eight status bits from the operand byte. Codes 28 to 31 leave the status byte unchanged and drive `result` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Commits the flag update of the current operation on the next edge |
| opCode | input | 5 | Operation code (see requirements) |
| accIn | input | 8 | Accumulator A |
| oprIn | input | 8 | Second operand, divisor, or new status byte |
| pairIn | input | 16 | Register pair, Y high and A low |
| wordIn | input | 16 | 16-bit memory operand |
| result | output | 16 | Combinational result |
| status | output | 8 | Registered status byte N V P B H I Z C |

## Verification
The add and subtract vectors are chosen so that each flag is the only thing separating two cases. A signed overflow at 0x7F+1 contrasts with a carry-only wrap at 0xFF+0+C. A borrow-in from a clear C is set against no borrow-out, and a borrow-out against a clean result. These cases expose any swap of the carry sense or of the operands in the V and H formulas. The 16-bit vectors cover the same edges on bit 15 and bit 16, and check that H is kept. The divide cases cover a remainder left after the last step, a quotient of exactly 0xFF, a zero divisor and a high byte equal to the divisor. Together they separate a correct restoring chain from one that drops a stage or tests overflow one value early. The flag operations start from all-ones and all-zeros status bytes, so a write that spills into a neighbouring bit shows up.

// File: rtl/cpu8_alu_pkg.sv
package cpu8_alu_pkg;

  localparam int OPW = 5;
  localparam int STW = 8;

  // status bit positions
  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_I = 2;
  localparam int SB_H = 3;
  localparam int SB_B = 4;
  localparam int SB_P = 5;
  localparam int SB_V = 6;
  localparam int SB_N = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADC  = 5'd0,  OP_SBC  = 5'd1,  OP_CMP  = 5'd2,  OP_AND  = 5'd3,
    OP_OR   = 5'd4,  OP_XOR  = 5'd5,  OP_ASL  = 5'd6,  OP_LSR  = 5'd7,
    OP_ROL  = 5'd8,  OP_ROR  = 5'd9,  OP_XCN  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_MOV  = 5'd13, OP_ADDW = 5'd14, OP_SUBW = 5'd15,
    OP_CMPW = 5'd16, OP_MUL  = 5'd17, OP_DIV  = 5'd18, OP_CLRC = 5'd19,
    OP_SETC = 5'd20, OP_NOTC = 5'd21, OP_CLRV = 5'd22, OP_CLRP = 5'd23,
    OP_SETP = 5'd24, OP_EI   = 5'd25, OP_DI   = 5'd26, OP_LDPS = 5'd27
  } aluOp_e;

  typedef enum logic [3:0] {
    U_NONE, U_ADD8, U_AND, U_OR, U_XOR, U_SHL, U_SHR, U_XCN,
    U_INC, U_DEC, U_PASS, U_ADD16, U_MUL, U_DIV
  } unitSel_e;

  typedef enum logic [2:0] {C_KEEP, C_ALU, C_SET, C_CLR, C_INV} cMode_e;
  typedef enum logic [1:0] {V_KEEP, V_ALU, V_CLR} vMode_e;
  typedef enum logic [1:0] {CIN_FLAG, CIN_ZERO, CIN_ONE} cinSel_e;

  typedef struct packed {
    logic     commit;
    unitSel_e unit;
    logic     invB;
    cinSel_e  cin;
    logic     rotFill;
    logic     resOn;
    logic     wrNZ;
    logic     wrH;
    cMode_e   cMode;
    vMode_e   vMode;
    logic     wrP;
    logic     pVal;
    logic     wrI;
    logic     iVal;
    logic     loadAll;
  } aluStrobe_t;

endpackage

// File: rtl/cpu8_alu_div.sv
module cpu8_alu_div #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic [W-1:0]   quot,
  output logic [W-1:0]   rem,
  output logic           ovf
);

  logic [W-1:0] remStage [0:W];
  logic [W-1:0] qBits;

  assign remStage[0] = dividend[2*W-1:W];

  for (genvar g = 0; g < W; g++) begin : gStage
    logic [W:0]   trial;
    logic         fits;
    logic [W-1:0] diff;
    assign trial = {remStage[g], dividend[W-1-g]};
    assign fits  = trial >= {1'b0, divisor};
    assign diff  = trial[W-1:0] - divisor;
    assign qBits[W-1-g]  = fits;
    assign remStage[g+1] = fits ? diff : trial[W-1:0];
  end

  assign ovf  = (divisor == '0) || (dividend[2*W-1:W] >= divisor);
  assign quot = ovf ? '1 : qBits;
  assign rem  = ovf ? dividend[W-1:0] : remStage[W];

endmodule

// File: rtl/cpu8_alu_ctrl.sv
module cpu8_alu_ctrl
  import cpu8_alu_pkg::*;
(
  input  logic            opValid,
  input  logic [OPW-1:0]  opCode,
  output aluStrobe_t      strb
);

  aluOp_e op;
  assign op = aluOp_e'(opCode);

  always_comb begin
    strb = '0;
    strb.commit = opValid && (opCode <= OP_LDPS);
    case (op)
      OP_ADC: begin
        strb.unit = U_ADD8; strb.resOn = 1'b1; strb.wrNZ = 1'b1; strb.wrH = 1'b1;
        strb.cMode = C_ALU; strb.vMode = V_ALU; strb.cin = CIN_FLAG;
      end
      OP_SBC: begin
        strb.unit = U_ADD8; strb.invB = 1'b1; strb.resOn = 1'b1; strb.wrNZ = 1'b1;
        strb.wrH = 1'b1; strb.cMode = C_ALU; strb.vMode = V_ALU; strb.cin = CIN_FLAG;
      end
      OP_CMP: begin
        strb.unit = U_ADD8; strb.invB = 1'b1; strb.cin = CIN_ONE;
        strb.wrNZ = 1'b1; strb.cMode = C_ALU;
      end
      OP_AND:  begin strb.unit = U_AND;  strb.resOn = 1'b1; strb.wrNZ = 1'b1; end
      OP_OR:   begin strb.unit = U_OR;   strb.resOn = 1'b1; strb.wrNZ = 1'b1; end
      OP_XOR:  begin strb.unit = U_XOR;  strb.resOn = 1'b1; strb.wrNZ = 1'b1; end
      OP_ASL:  begin strb.unit = U_SHL;  strb.resOn = 1'b1; strb.wrNZ = 1'b1; strb.cMode = C_ALU; end
      OP_LSR:  begin strb.unit = U_SHR;  strb.resOn = 1'b1; strb.wrNZ = 1'b1; strb.cMode = C_ALU; end
      OP_ROL: begin
        strb.unit = U_SHL; strb.rotFill = 1'b1; strb.resOn = 1'b1; strb.wrNZ = 1'b1; strb.cMode = C_ALU;
      end
      OP_ROR: begin
        strb.unit = U_SHR; strb.rotFill = 1'b1; strb.resOn = 1'b1; strb.wrNZ = 1'b1; strb.cMode = C_ALU;
      end
      OP_XCN:  begin strb.unit = U_XCN;  strb.resOn = 1'b1; strb.wrNZ = 1'b1; end
      OP_INC:  begin strb.unit = U_INC;  strb.resOn = 1'b1; strb.wrNZ = 1'b1; end
      OP_DEC:  begin strb.unit = U_DEC;  strb.resOn = 1'b1; strb.wrNZ = 1'b1; end
      OP_MOV:  begin strb.unit = U_PASS; strb.resOn = 1'b1; strb.wrNZ = 1'b1; end
      OP_ADDW: begin
        strb.unit = U_ADD16; strb.cin = CIN_ZERO; strb.resOn = 1'b1; strb.wrNZ = 1'b1;
        strb.cMode = C_ALU; strb.vMode = V_ALU;
      end
      OP_SUBW: begin
        strb.unit = U_ADD16; strb.invB = 1'b1; strb.cin = CIN_ONE; strb.resOn = 1'b1;
        strb.wrNZ = 1'b1; strb.cMode = C_ALU; strb.vMode = V_ALU;
      end
      OP_CMPW: begin
        strb.unit = U_ADD16; strb.invB = 1'b1; strb.cin = CIN_ONE;
        strb.wrNZ = 1'b1; strb.cMode = C_ALU;
      end
      OP_MUL:  begin strb.unit = U_MUL; strb.resOn = 1'b1; strb.wrNZ = 1'b1; end
      OP_DIV:  begin strb.unit = U_DIV; strb.resOn = 1'b1; strb.wrNZ = 1'b1; strb.vMode = V_ALU; end
      OP_CLRC: strb.cMode = C_CLR;
      OP_SETC: strb.cMode = C_SET;
      OP_NOTC: strb.cMode = C_INV;
      OP_CLRV: strb.vMode = V_CLR;
      OP_CLRP: begin strb.wrP = 1'b1; strb.pVal = 1'b0; end
      OP_SETP: begin strb.wrP = 1'b1; strb.pVal = 1'b1; end
      OP_EI:   begin strb.wrI = 1'b1; strb.iVal = 1'b1; end
      OP_DI:   begin strb.wrI = 1'b1; strb.iVal = 1'b0; end
      OP_LDPS: strb.loadAll = 1'b1;
      default: strb.commit = 1'b0;
    endcase
  end

endmodule

// File: rtl/cpu8_alu_dpath.sv
module cpu8_alu_dpath
  import cpu8_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strb,
  input  logic [DW-1:0]     accIn,
  input  logic [DW-1:0]     oprIn,
  input  logic [2*DW-1:0]   pairIn,
  input  logic [2*DW-1:0]   wordIn,
  output logic [2*DW-1:0]   result,
  output logic [STW-1:0]    status
);

  localparam int WW = 2 * DW;
  localparam int HB = DW / 2;

  logic [STW-1:0] statusQ;
  logic [STW-1:0] statusNxt;
  logic           cFlag;
  logic           cin;

  assign cFlag = statusQ[SB_C];

  always_comb begin
    case (strb.cin)
      CIN_FLAG: cin = cFlag;
      CIN_ONE:  cin = 1'b1;
      default:  cin = 1'b0;
    endcase
  end

  // 8-bit adder shared by add, subtract and compare
  logic [DW-1:0] bEff8;
  logic [DW:0]   sum8;
  logic [DW-1:0] res8;
  logic          c8, v8, h8;
  assign bEff8 = strb.invB ? ~oprIn : oprIn;
  assign sum8  = {1'b0, accIn} + {1'b0, bEff8} + {{DW{1'b0}}, cin};
  assign res8  = sum8[DW-1:0];
  assign c8    = sum8[DW];
  assign v8    = (accIn[DW-1] ^ res8[DW-1]) & (bEff8[DW-1] ^ res8[DW-1]);
  assign h8    = accIn[HB] ^ oprIn[HB] ^ res8[HB];

  // 16-bit adder for the register pair
  logic [WW-1:0] bEff16;
  logic [WW:0]   sum16;
  logic [WW-1:0] res16;
  logic          c16, v16;
  assign bEff16 = strb.invB ? ~wordIn : wordIn;
  assign sum16  = {1'b0, pairIn} + {1'b0, bEff16} + {{WW{1'b0}}, cin};
  assign res16  = sum16[WW-1:0];
  assign c16    = sum16[WW];
  assign v16    = (pairIn[WW-1] ^ res16[WW-1]) & (bEff16[WW-1] ^ res16[WW-1]);

  // shifts, nibble swap, step
  logic          fill;
  logic [DW-1:0] shl, shr, xcn, incV, decV;
  assign fill = strb.rotFill & cFlag;
  assign shl  = {accIn[DW-2:0], fill};
  assign shr  = {fill, accIn[DW-1:1]};
  assign xcn  = {accIn[HB-1:0], accIn[DW-1:HB]};
  assign incV = accIn + {{(DW-1){1'b0}}, 1'b1};
  assign decV = accIn - {{(DW-1){1'b0}}, 1'b1};

  // multiply and divide
  logic [WW-1:0] prod;
  logic [DW-1:0] quot, rem;
  logic          divOvf;
  assign prod = {{DW{1'b0}}, pairIn[DW-1:0]} * {{DW{1'b0}}, pairIn[WW-1:DW]};

  cpu8_alu_div #(.W(DW)) u_div (
    .dividend (pairIn),
    .divisor  (oprIn),
    .quot     (quot),
    .rem      (rem),
    .ovf      (divOvf)
  );

  // unit select
  logic [WW-1:0] valAll;
  logic          wide;
  logic          nNew, zNew, cNew, vNew;

  always_comb begin
    valAll = '0;
    case (strb.unit)
      U_ADD8:  valAll = {{DW{1'b0}}, res8};
      U_AND:   valAll = {{DW{1'b0}}, accIn & oprIn};
      U_OR:    valAll = {{DW{1'b0}}, accIn | oprIn};
      U_XOR:   valAll = {{DW{1'b0}}, accIn ^ oprIn};
      U_SHL:   valAll = {{DW{1'b0}}, shl};
      U_SHR:   valAll = {{DW{1'b0}}, shr};
      U_XCN:   valAll = {{DW{1'b0}}, xcn};
      U_INC:   valAll = {{DW{1'b0}}, incV};
      U_DEC:   valAll = {{DW{1'b0}}, decV};
      U_PASS:  valAll = {{DW{1'b0}}, oprIn};
      U_ADD16: valAll = res16;
      U_MUL:   valAll = prod;
      U_DIV:   valAll = {rem, quot};
      default: valAll = '0;
    endcase
  end

  assign wide = (strb.unit == U_ADD16) || (strb.unit == U_MUL);
  assign nNew = wide ? valAll[WW-1] : valAll[DW-1];
  assign zNew = wide ? (valAll == '0) : (valAll[DW-1:0] == '0);

  always_comb begin
    case (strb.unit)
      U_ADD16: cNew = c16;
      U_SHL:   cNew = accIn[DW-1];
      U_SHR:   cNew = accIn[0];
      default: cNew = c8;
    endcase
    case (strb.unit)
      U_ADD16: vNew = v16;
      U_DIV:   vNew = divOvf;
      default: vNew = v8;
    endcase
  end

  assign result = strb.resOn ? valAll : '0;

  // status update
  always_comb begin
    statusNxt = statusQ;
    if (strb.loadAll) statusNxt = STW'(oprIn);
    if (strb.wrNZ) begin
      statusNxt[SB_N] = nNew;
      statusNxt[SB_Z] = zNew;
    end
    if (strb.wrH) statusNxt[SB_H] = h8;
    case (strb.cMode)
      C_ALU:   statusNxt[SB_C] = cNew;
      C_SET:   statusNxt[SB_C] = 1'b1;
      C_CLR:   statusNxt[SB_C] = 1'b0;
      C_INV:   statusNxt[SB_C] = ~cFlag;
      default: ;
    endcase
    case (strb.vMode)
      V_ALU:   statusNxt[SB_V] = vNew;
      V_CLR:   statusNxt[SB_V] = 1'b0;
      default: ;
    endcase
    if (strb.wrP) statusNxt[SB_P] = strb.pVal;
    if (strb.wrI) statusNxt[SB_I] = strb.iVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            statusQ <= '0;
    else if (strb.commit) statusQ <= statusNxt;
  end

  assign status = statusQ;

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OPW-1:0]    opCode,
  input  logic [DW-1:0]     accIn,
  input  logic [DW-1:0]     oprIn,
  input  logic [2*DW-1:0]   pairIn,
  input  logic [2*DW-1:0]   wordIn,
  output logic [2*DW-1:0]   result,
  output logic [STW-1:0]    status
);

  aluStrobe_t strb;

  cpu8_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strb    (strb)
  );

  cpu8_alu_dpath #(.DW(DW)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .accIn  (accIn),
    .oprIn  (oprIn),
    .pairIn (pairIn),
    .wordIn (wordIn),
    .result (result),
    .status (status)
  );

endmodule

// File: rtl/cpu8_alu_chk.sv
module cpu8_alu_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            opValid,
  input logic [4:0]      opCode,
  input logic [DW-1:0]   oprIn,
  input logic [2*DW-1:0] pairIn,
  input logic [2*DW-1:0] result,
  input logic [7:0]      status
);

  // R1: no commit without opValid
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(status));

  // R4: compare keeps V and H
  a_r4_cmp_keep: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 5'd2) |=>
      (status[6] == $past(status[6])) && (status[3] == $past(status[3])));

  // R5: move sets Z from the operand
  a_r5_mov_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 5'd13) |=> (status[1] == ($past(oprIn) == '0)));

  // R11: quotient and remainder rebuild the dividend
  a_r11_div_identity: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 5'd18 && oprIn != '0 && pairIn[2*DW-1:DW] < oprIn) |->
      (({{DW{1'b0}}, result[DW-1:0]} * {{DW{1'b0}}, oprIn}
        + {{DW{1'b0}}, result[2*DW-1:DW]}) == pairIn)
      && (result[2*DW-1:DW] < oprIn));

  // R12: divide by zero gives the saturated answer and V
  a_r12_div_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 5'd18 && oprIn == '0) |->
      (result[DW-1:0] == '1) && (result[2*DW-1:DW] == pairIn[DW-1:0]));

  a_r12_div_zero_v: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 5'd18 && oprIn == '0) |=> status[6]);

  // R13: set carry
  a_r13_setc: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 5'd20) |=> status[0]);

  // R14: undefined codes leave status alone
  a_r14_undef: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= 5'd28) |=> $stable(status));

endmodule

bind cpu8_alu cpu8_alu_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opCode  (opCode),
  .oprIn   (oprIn),
  .pairIn  (pairIn),
  .result  (result),
  .status  (status)
);

// File: tb/sim_cpu8_alu.sv
module sim_cpu8_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opCode = '0;
  logic [7:0]  accIn = '0;
  logic [7:0]  oprIn = '0;
  logic [15:0] pairIn = '0;
  logic [15:0] wordIn = '0;
  logic [15:0] result;
  logic [7:0]  status;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cpu8_alu u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .oprIn(oprIn), .pairIn(pairIn), .wordIn(wordIn),
    .result(result), .status(status)
  );

  // {req, op, acc, opr, pair, word, statusBefore, expResult, expStatus}
  localparam int VW = 89;
  localparam int NV = 42;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2,  5'd0,  8'h7F, 8'h01, 16'h0000, 16'h0000, 8'h00, 16'h0080, 8'hC8}, // R2 signed overflow
    {4'd2,  5'd0,  8'hFF, 8'h00, 16'h0000, 16'h0000, 8'h01, 16'h0000, 8'h0B}, // R2 carry in wraps
    {4'd3,  5'd1,  8'h50, 8'h20, 16'h0000, 16'h0000, 8'h01, 16'h0030, 8'h01}, // R3 no borrow
    {4'd3,  5'd1,  8'h80, 8'h01, 16'h0000, 16'h0000, 8'h00, 16'h007E, 8'h49}, // R3 borrow in, overflow
    {4'd3,  5'd1,  8'h10, 8'h20, 16'h0000, 16'h0000, 8'h25, 16'h00F0, 8'hA4}, // R3 borrow out
    {4'd4,  5'd2,  8'h40, 8'h40, 16'h0000, 16'h0000, 8'h48, 16'h0000, 8'h4B}, // R4 equal
    {4'd4,  5'd2,  8'h10, 8'h20, 16'h0000, 16'h0000, 8'h01, 16'h0000, 8'h80}, // R4 below
    {4'd5,  5'd3,  8'hF0, 8'h0F, 16'h0000, 16'h0000, 8'h01, 16'h0000, 8'h03}, // R5 and
    {4'd5,  5'd4,  8'h01, 8'h80, 16'h0000, 16'h0000, 8'h02, 16'h0081, 8'h80}, // R5 or
    {4'd5,  5'd5,  8'hAA, 8'h55, 16'h0000, 16'h0000, 8'h00, 16'h00FF, 8'h80}, // R5 xor
    {4'd5,  5'd11, 8'hFF, 8'h00, 16'h0000, 16'h0000, 8'h01, 16'h0000, 8'h03}, // R5 inc wrap
    {4'd5,  5'd12, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'h02, 16'h00FF, 8'h80}, // R5 dec wrap
    {4'd5,  5'd13, 8'h55, 8'h00, 16'h0000, 16'h0000, 8'h80, 16'h0000, 8'h02}, // R5 move zero
    {4'd6,  5'd6,  8'h81, 8'h00, 16'h0000, 16'h0000, 8'h00, 16'h0002, 8'h01}, // R6 asl
    {4'd6,  5'd6,  8'h40, 8'h00, 16'h0000, 16'h0000, 8'h01, 16'h0080, 8'h80}, // R6 asl ignores C
    {4'd6,  5'd8,  8'h40, 8'h00, 16'h0000, 16'h0000, 8'h01, 16'h0081, 8'h80}, // R6 rol
    {4'd6,  5'd7,  8'h01, 8'h00, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h03}, // R6 lsr
    {4'd6,  5'd9,  8'h02, 8'h00, 16'h0000, 16'h0000, 8'h01, 16'h0081, 8'h80}, // R6 ror
    {4'd7,  5'd10, 8'h3C, 8'h00, 16'h0000, 16'h0000, 8'h00, 16'h00C3, 8'h80}, // R7 swap
    {4'd8,  5'd14, 8'h00, 8'h00, 16'h7FFF, 16'h0001, 8'h01, 16'h8000, 8'hC0}, // R8 addw overflow
    {4'd8,  5'd14, 8'h00, 8'h00, 16'hFFFF, 16'h0001, 8'h08, 16'h0000, 8'h0B}, // R8 addw carry, H kept
    {4'd8,  5'd15, 8'h00, 8'h00, 16'h1000, 16'h2000, 8'h00, 16'hF000, 8'h80}, // R8 subw borrow
    {4'd9,  5'd16, 8'h00, 8'h00, 16'h1234, 16'h1234, 8'h40, 16'h0000, 8'h43}, // R9 equal
    {4'd9,  5'd16, 8'h00, 8'h00, 16'h0001, 16'h0002, 8'h00, 16'h0000, 8'h80}, // R9 below
    {4'd10, 5'd17, 8'h00, 8'h00, 16'h1020, 16'h0000, 8'h41, 16'h0200, 8'h41}, // R10 plain
    {4'd10, 5'd17, 8'h00, 8'h00, 16'hFFFF, 16'h0000, 8'h02, 16'hFE01, 8'h80}, // R10 bit 15
    {4'd10, 5'd17, 8'h00, 8'h00, 16'h3400, 16'h0000, 8'h00, 16'h0000, 8'h02}, // R10 zero
    {4'd11, 5'd18, 8'h00, 8'h10, 16'h0107, 16'h0000, 8'h41, 16'h0710, 8'h01}, // R11 remainder
    {4'd11, 5'd18, 8'h00, 8'h09, 16'h0005, 16'h0000, 8'h00, 16'h0500, 8'h02}, // R11 zero quotient
    {4'd11, 5'd18, 8'h00, 8'h0A, 16'h09FF, 16'h0000, 8'h00, 16'h09FF, 8'h80}, // R11 quotient 0xFF
    {4'd12, 5'd18, 8'h00, 8'h00, 16'h1234, 16'h0000, 8'h01, 16'h34FF, 8'hC1}, // R12 zero divisor
    {4'd12, 5'd18, 8'h00, 8'h20, 16'h2000, 16'h0000, 8'h00, 16'h00FF, 8'hC0}, // R12 high byte equal
    {4'd13, 5'd19, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'hFF, 16'h0000, 8'hFE}, // R13 clrc
    {4'd13, 5'd20, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h01}, // R13 setc
    {4'd13, 5'd21, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'h01, 16'h0000, 8'h00}, // R13 notc
    {4'd13, 5'd22, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'hFF, 16'h0000, 8'hBF}, // R13 clrv
    {4'd13, 5'd23, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'hFF, 16'h0000, 8'hDF}, // R13 clrp
    {4'd13, 5'd24, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h20}, // R13 setp
    {4'd13, 5'd25, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h04}, // R13 ei
    {4'd13, 5'd26, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'hFF, 16'h0000, 8'hFB}, // R13 di
    {4'd14, 5'd27, 8'h00, 8'h5A, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h5A}, // R14 load
    {4'd14, 5'd28, 8'h12, 8'h34, 16'h5678, 16'h9ABC, 8'hA5, 16'h0000, 8'hA5}  // R14 undefined
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadStatus(input logic [7:0] s);
    @(negedge clk);
    opValid = 1'b1; opCode = 5'd27; oprIn = s;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic runVec(input logic [VW-1:0] v, input int idx);
    loadStatus(v[31:24]);
    opValid = 1'b1;
    opCode = v[84:80]; accIn = v[79:72]; oprIn = v[71:64];
    pairIn = v[63:48]; wordIn = v[47:32];
    #1;
    check($sformatf("R%0d vec%0d result", v[88:85], idx), result, v[23:8]);
    @(negedge clk);
    opValid = 1'b0;
    check($sformatf("R%0d vec%0d status", v[88:85], idx), {8'h00, status}, {8'h00, v[7:0]});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset status", {8'h00, status}, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status after release", {8'h00, status}, 16'h0000);

    for (int i = 0; i < NV; i++) runVec(VEC[i], i);

    // R1: opValid low blocks a commit
    loadStatus(8'h3C);
    opValid = 1'b0; opCode = 5'd20;
    @(negedge clk);
    check("R1 hold setc", {8'h00, status}, 16'h003C);
    opCode = 5'd27; oprIn = 8'hFF;
    @(negedge clk);
    check("R1 hold load", {8'h00, status}, 16'h003C);

    // R2: carry chained through two ADCs
    loadStatus(8'h00);
    opValid = 1'b1; opCode = 5'd0; accIn = 8'hF0; oprIn = 8'h20;
    #1 check("R2 chain low byte", result, 16'h0010);
    @(negedge clk);
    accIn = 8'h01; oprIn = 8'h01;
    #1 check("R2 chain high byte", result, 16'h0003);
    @(negedge clk);
    opValid = 1'b0;
    check("R2 chain status", {8'h00, status}, 16'h0000);

    // R12: back-to-back zero divides stay defined
    loadStatus(8'h00);
    opValid = 1'b1; opCode = 5'd18; oprIn = 8'h00; pairIn = 16'h00AB;
    #1 check("R12 repeat zero divide result", result, 16'hABFF);
    @(negedge clk);
    pairIn = 16'hFF00;
    #1 check("R12 second zero divide result", result, 16'h00FF);
    @(negedge clk);
    opValid = 1'b0;
    check("R12 zero divide status", {8'h00, status}, 16'h00C0);

    // R1: reset in mid-run clears a full status byte
    loadStatus(8'hFF);
    rstN = 1'b0;
    #2 check("R1 async reset", {8'h00, status}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after second reset", {8'h00, status}, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule